// File: doc/BRIEF.md
# Video acquisition window generator

This block watches a pixel stream that arrives with a per-pixel qualifier and two reference strobes, one horizontal and one vertical. It keeps its own count of qualified pixels within the current line and of lines that held at least one qualified pixel since the last vertical reference. From these counts it marks a rectangle of the source picture. The rectangle begins at a programmable pixel and line offset. It ends at whichever is smaller: the programmed source length or the programmed destination size.

Downstream logic uses the in-window flag as a capture enable. Alongside it the block supplies the pixel and line position inside the rectangle, plus single-cycle markers on the first and the last pixel of each captured line. Each strobe can trigger on either its rising or its falling edge. The rectangle settings are sampled only at a vertical reference, so any one field is always cut with a single, consistent rectangle.

Top module: `vid_acq_window`

## Requirements
- R1: After reset all outputs are 0 and the captured rectangle settings are zero, so no pixel is in the window until the first vertical reference event.
- R2: Only a cycle with `pix_vld`=1 that is not itself a reference event advances the pixel index. `win_x` equals that pixel's index within the line minus `xoff`.
- R3: A horizontal reference event advances the line index only if the line just ended held a qualified pixel. `win_y` equals the line index minus `yoff`.
- R4: A qualified pixel is horizontally inside the window when xoff <= index < xoff + min(xlen, xdst).
- R5: A line is vertically inside the window when yoff <= line index < yoff + min(ylen, ydst).
- R6: A value of 0 for `xdst` or for `ydst` keeps the window closed for the whole field.
- R7: A vertical reference event resets both indices to 0. If fewer lines arrive than the window asks for, the window simply ends with the field and no extra lines are produced.
- R8: `line_start` pulses with the in-window pixel whose index equals `xoff`. `line_end` pulses with the in-window pixel whose index equals xoff + min(xlen, xdst) - 1. Both are only ever high together with `win_vld`.
- R9: `h_edge_fall`=0 makes a rising edge of `href` the horizontal event, and 1 makes it the falling edge. `v_edge_fall` selects the edge of `vref` in the same way. The event is taken in the cycle where the new level is seen.
- R10: The six rectangle inputs are captured in the cycle of a vertical reference event. Changes to them at any other time have no effect until the next such event.
- R11: The outputs are registered. They describe the input cycle one clock earlier, and a pixel presented in a reference-event cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Pixel qualifier |
| href | input | 1 | Horizontal reference strobe |
| vref | input | 1 | Vertical reference strobe |
| h_edge_fall | input | 1 | 1: falling edge of href is the event |
| v_edge_fall | input | 1 | 1: falling edge of vref is the event |
| xoff | input | 12 | Horizontal offset, source pixels |
| xlen | input | 12 | Horizontal source length |
| xdst | input | 12 | Horizontal destination size |
| yoff | input | 12 | Vertical offset, source lines |
| ylen | input | 12 | Vertical source length |
| ydst | input | 12 | Vertical destination size |
| win_vld | output | 1 | Pixel of previous cycle is in the window |
| win_x | output | 12 | Pixel position inside the window |
| win_y | output | 12 | Line position inside the window |
| line_start | output | 1 | First in-window pixel of a line |
| line_end | output | 1 | Last in-window pixel of a line |

## Verification
The window is exercised with solid runs of qualified pixels and with runs broken by idle cycles. Runs broken by idle cycles show whether the index counts qualified pixels or clock cycles. Fields that mix empty lines with occupied ones separate counting lines by strobe from counting lines by content. Two rectangle shapes are used: one where the source length is the smaller limit and one where the destination size is. Together they show which limit closes each axis. Wide strobes that carry pixels while high tell rising-edge triggering from falling-edge triggering. Short fields followed by a fresh field, and settings changed in mid-field, expose lines padded past the end of a field and settings applied too early.

// File: rtl/vaw_pkg.sv
package vaw_pkg;
  localparam int VAW_CW = 12;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_e;
endpackage

// File: rtl/vaw_edge.sv
module vaw_edge
  import vaw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic fall_i,
  output logic evt_o
);
  logic  sig_q;
  edge_e sel;

  assign sel   = edge_e'(fall_i);
  assign evt_o = (sel == EDGE_FALL) ? (sig_q & ~sig_i) : (~sig_q & sig_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end
endmodule

// File: rtl/vaw_count.sv
module vaw_count #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_evt,
  input  logic          v_evt,
  input  logic          pix_vld,
  output logic          pix_ok,
  output logic [CW-1:0] pcnt,
  output logic [CW-1:0] lcnt
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] pcnt_q, pcnt_d, lcnt_q, lcnt_d;
  logic          hit_q, hit_d;

  assign pix_ok = pix_vld & ~h_evt & ~v_evt;
  assign pcnt   = pcnt_q;
  assign lcnt   = lcnt_q;

  always_comb begin
    pcnt_d = pcnt_q;
    lcnt_d = lcnt_q;
    hit_d  = hit_q;
    if (v_evt) begin
      pcnt_d = '0;
      lcnt_d = '0;
      hit_d  = 1'b0;
    end else if (h_evt) begin
      pcnt_d = '0;
      hit_d  = 1'b0;
      if (hit_q && (lcnt_q != CMAX)) lcnt_d = lcnt_q + 1'b1;
    end else if (pix_ok) begin
      hit_d = 1'b1;
      if (pcnt_q != CMAX) pcnt_d = pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      lcnt_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      lcnt_q <= lcnt_d;
      hit_q  <= hit_d;
    end
  end
endmodule

// File: rtl/vaw_win.sv
module vaw_win #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_evt,
  input  logic          pix_ok,
  input  logic [CW-1:0] pcnt,
  input  logic [CW-1:0] lcnt,
  input  logic [CW-1:0] xoff,
  input  logic [CW-1:0] xlen,
  input  logic [CW-1:0] xdst,
  input  logic [CW-1:0] yoff,
  input  logic [CW-1:0] ylen,
  input  logic [CW-1:0] ydst,
  output logic          win_vld,
  output logic [CW-1:0] win_x,
  output logic [CW-1:0] win_y,
  output logic          line_start,
  output logic          line_end
);
  localparam int EW = CW + 1;

  // rectangle captured at the vertical event
  logic [CW-1:0] xo_q, xl_q, xd_q, yo_q, yl_q, yd_q;
  logic [CW-1:0] xspan, yspan;
  logic [EW-1:0] xend, yend;
  logic          in_x, in_y, hit_d, sol_d, eol_d;
  logic [CW-1:0] wx_d, wy_d;
  logic          win_q, sol_q, eol_q;
  logic [CW-1:0] wx_q, wy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xo_q <= '0; xl_q <= '0; xd_q <= '0;
      yo_q <= '0; yl_q <= '0; yd_q <= '0;
    end else if (v_evt) begin
      xo_q <= xoff; xl_q <= xlen; xd_q <= xdst;
      yo_q <= yoff; yl_q <= ylen; yd_q <= ydst;
    end
  end

  always_comb begin
    xspan = (xl_q < xd_q) ? xl_q : xd_q;
    yspan = (yl_q < yd_q) ? yl_q : yd_q;
    xend  = {1'b0, xo_q} + {1'b0, xspan};
    yend  = {1'b0, yo_q} + {1'b0, yspan};
    in_x  = (pcnt >= xo_q) && ({1'b0, pcnt} < xend);
    in_y  = (lcnt >= yo_q) && ({1'b0, lcnt} < yend);
    hit_d = pix_ok & in_x & in_y;
    sol_d = hit_d & (pcnt == xo_q);
    eol_d = hit_d & ({1'b0, pcnt} == (xend - 1'b1));
    wx_d  = hit_d ? (pcnt - xo_q) : '0;
    wy_d  = hit_d ? (lcnt - yo_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0; sol_q <= 1'b0; eol_q <= 1'b0;
      wx_q  <= '0;   wy_q  <= '0;
    end else begin
      win_q <= hit_d; sol_q <= sol_d; eol_q <= eol_d;
      wx_q  <= wx_d;  wy_q  <= wy_d;
    end
  end

  assign win_vld    = win_q;
  assign win_x      = wx_q;
  assign win_y      = wy_q;
  assign line_start = sol_q;
  assign line_end   = eol_q;
endmodule

// File: rtl/vid_acq_window.sv
module vid_acq_window #(
  parameter int CW = vaw_pkg::VAW_CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_vld,
  input  logic          href,
  input  logic          vref,
  input  logic          h_edge_fall,
  input  logic          v_edge_fall,
  input  logic [CW-1:0] xoff,
  input  logic [CW-1:0] xlen,
  input  logic [CW-1:0] xdst,
  input  logic [CW-1:0] yoff,
  input  logic [CW-1:0] ylen,
  input  logic [CW-1:0] ydst,
  output logic          win_vld,
  output logic [CW-1:0] win_x,
  output logic [CW-1:0] win_y,
  output logic          line_start,
  output logic          line_end
);
  localparam int NREF = 2;

  logic [NREF-1:0] ref_in, ref_sel, ref_evt;
  logic            pix_ok;
  logic [CW-1:0]   pcnt, lcnt;

  assign ref_in  = {vref, href};
  assign ref_sel = {v_edge_fall, h_edge_fall};

  for (genvar g = 0; g < NREF; g++) begin : g_edge
    vaw_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (ref_in[g]),
      .fall_i (ref_sel[g]),
      .evt_o  (ref_evt[g])
    );
  end

  vaw_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_evt   (ref_evt[0]),
    .v_evt   (ref_evt[1]),
    .pix_vld (pix_vld),
    .pix_ok  (pix_ok),
    .pcnt    (pcnt),
    .lcnt    (lcnt)
  );

  vaw_win #(.CW(CW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .v_evt      (ref_evt[1]),
    .pix_ok     (pix_ok),
    .pcnt       (pcnt),
    .lcnt       (lcnt),
    .xoff       (xoff),
    .xlen       (xlen),
    .xdst       (xdst),
    .yoff       (yoff),
    .ylen       (ylen),
    .ydst       (ydst),
    .win_vld    (win_vld),
    .win_x      (win_x),
    .win_y      (win_y),
    .line_start (line_start),
    .line_end   (line_end)
  );
endmodule

// File: rtl/vaw_chk.sv
module vaw_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_vld,
  input logic          win_vld,
  input logic [CW-1:0] win_x,
  input logic          line_start,
  input logic          line_end
);
  a_r8_start_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> win_vld);

  a_r8_end_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> win_vld);

  a_r8_start_at_x0: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (win_x == '0));

  a_r11_window_needs_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> $past(pix_vld));

  a_r2_x_zero_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |-> (win_x == '0));
endmodule

bind vid_acq_window vaw_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_vld    (pix_vld),
  .win_vld    (win_vld),
  .win_x      (win_x),
  .line_start (line_start),
  .line_end   (line_end)
);

// File: tb/vid_acq_window_tb.sv
`timescale 1ns/1ps
module vid_acq_window_tb;
  localparam int CW = 12;

  logic clk, rst_n, pix_vld, href, vref, h_edge_fall, v_edge_fall;
  logic [CW-1:0] xoff, xlen, xdst, yoff, ylen, ydst;
  logic win_vld, line_start, line_end;
  logic [CW-1:0] win_x, win_y;

  int n_chk, n_fail;
  string cur_req;

  // bench model state
  logic m_h, m_v, m_hit;
  int m_p, m_l, s_xo, s_xl, s_xd, s_yo, s_yl, s_yd;

  vid_acq_window #(.CW(CW)) u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hang, expected completion)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic set_cfg(input int xo, xl, xd, yo, yl, yd);
    @(negedge clk);
    xoff = CW'(xo); xlen = CW'(xl); xdst = CW'(xd);
    yoff = CW'(yo); ylen = CW'(yl); ydst = CW'(yd);
  endtask

  // one input cycle, checked against the model one clock later
  task automatic step(input logic h, input logic v, input logic q);
    logic hev, vev, ok, ew, es, ee;
    int xe, ye, ex, ey;
    @(negedge clk);
    href = h; vref = v; pix_vld = q;
    hev = h_edge_fall ? (m_h & ~h) : (~m_h & h);
    vev = v_edge_fall ? (m_v & ~v) : (~m_v & v);
    ok  = q & ~hev & ~vev;
    xe  = s_xo + imin(s_xl, s_xd);
    ye  = s_yo + imin(s_yl, s_yd);
    ew  = ok && (m_p >= s_xo) && (m_p < xe) && (m_l >= s_yo) && (m_l < ye);
    es  = ew && (m_p == s_xo);
    ee  = ew && (m_p == xe - 1);
    ex  = m_p - s_xo;
    ey  = m_l - s_yo;
    if (vev) begin
      m_p = 0; m_l = 0; m_hit = 1'b0;
      s_xo = int'(xoff); s_xl = int'(xlen); s_xd = int'(xdst);
      s_yo = int'(yoff); s_yl = int'(ylen); s_yd = int'(ydst);
    end else if (hev) begin
      if (m_hit) m_l++;
      m_p = 0; m_hit = 1'b0;
    end else if (ok) begin
      m_p++; m_hit = 1'b1;
    end
    m_h = h; m_v = v;
    @(posedge clk); #1;
    chk(cur_req, int'(win_vld), int'(ew));
    chk("R8", int'(line_start), int'(es));
    chk("R8", int'(line_end), int'(ee));
    if (ew) begin
      chk("R2", int'(win_x), ex);
      chk("R3", int'(win_y), ey);
    end
  endtask

  task automatic vsync();
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
  endtask

  // a line: strobe, then npix qualified pixels, an idle cycle after every gap-th one
  task automatic line(input int npix, input int gap);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < npix; i++) begin
      step(1'b0, 1'b0, 1'b1);
      if (gap > 0 && (i % gap) == gap - 1) step(1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic empty_line();
    step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  // R1: reset state, and no window before the first vertical event
  task automatic t_reset();
    cur_req = "R1";
    chk("R1", int'(win_vld), 0);
    chk("R1", int'(win_x), 0);
    chk("R1", int'(line_start), 0);
    chk("R1", int'(line_end), 0);
    set_cfg(0, 8, 8, 0, 4, 4);
    for (int l = 0; l < 3; l++) line(8, 0);
  endtask

  // R4: source length is the horizontal limit; R5 too
  task automatic t_basic();
    cur_req = "R4";
    set_cfg(2, 5, 9, 1, 2, 5);
    vsync();
    for (int l = 0; l < 5; l++) line(10, 0);
  endtask

  // R5: destination sizes close both axes, R2 with idle gaps
  task automatic t_dst();
    cur_req = "R5";
    set_cfg(1, 8, 3, 0, 6, 2);
    vsync();
    for (int l = 0; l < 4; l++) line(9, 2);
  endtask

  // R3: lines without qualified pixels are not counted
  task automatic t_empty();
    cur_req = "R3";
    set_cfg(0, 4, 4, 1, 3, 3);
    vsync();
    line(5, 0);
    empty_line();
    empty_line();
    line(5, 3);
    empty_line();
    line(5, 0);
    line(5, 0);
  endtask

  // R6: zero destination size keeps the window shut
  task automatic t_zero();
    cur_req = "R6";
    set_cfg(0, 6, 0, 0, 4, 4);
    vsync();
    for (int l = 0; l < 3; l++) line(6, 0);
    set_cfg(0, 6, 6, 0, 4, 0);
    vsync();
    for (int l = 0; l < 3; l++) line(6, 0);
  endtask

  // R7: short field, then a new field restarts at line 0
  task automatic t_trunc();
    cur_req = "R7";
    set_cfg(0, 3, 3, 1, 20, 20);
    vsync();
    for (int l = 0; l < 3; l++) line(4, 0);
    vsync();
    line(4, 0);
    line(4, 0);
  endtask

  // R10: mid-field register change waits for the vertical event
  task automatic t_shadow();
    cur_req = "R10";
    set_cfg(1, 3, 3, 0, 5, 5);
    vsync();
    line(6, 0);
    set_cfg(3, 2, 2, 2, 1, 1);
    line(6, 0);
    line(6, 0);
    vsync();
    for (int l = 0; l < 4; l++) line(6, 0);
  endtask

  // R9: edge selection, pixels carried while the strobe is high
  task automatic wide_line(input logic vstrobe);
    if (vstrobe) step(1'b0, 1'b1, 1'b0); else step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      if (vstrobe) step(1'b0, 1'b1, 1'b1); else step(1'b1, 1'b0, 1'b1);
    end
    step(1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_edge();
    cur_req = "R9";
    set_cfg(2, 4, 4, 0, 6, 6);
    h_edge_fall = 1'b1;
    vsync();
    for (int l = 0; l < 3; l++) wide_line(1'b0);
    h_edge_fall = 1'b0;
    vsync();
    for (int l = 0; l < 3; l++) wide_line(1'b0);
    v_edge_fall = 1'b1;
    set_cfg(1, 5, 5, 0, 3, 3);
    wide_line(1'b1);
    line(6, 0);
    v_edge_fall = 1'b0;
    vsync();
  endtask

  // R11: a pixel presented on the reference event itself is dropped
  task automatic t_evtpix();
    cur_req = "R11";
    set_cfg(0, 4, 4, 0, 3, 3);
    vsync();
    for (int l = 0; l < 2; l++) begin
      step(1'b1, 1'b0, 1'b1);
      step(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1);
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; cur_req = "R1";
    rst_n = 1'b0; pix_vld = 1'b0; href = 1'b0; vref = 1'b0;
    h_edge_fall = 1'b0; v_edge_fall = 1'b0;
    xoff = '0; xlen = '0; xdst = '0; yoff = '0; ylen = '0; ydst = '0;
    m_h = 1'b0; m_v = 1'b0; m_hit = 1'b0; m_p = 0; m_l = 0;
    s_xo = 0; s_xl = 0; s_xd = 0; s_yo = 0; s_yl = 0; s_yd = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_dst();
    t_empty();
    t_zero();
    t_trunc();
    t_shadow();
    t_edge();
    t_evtpix();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule